// File: doc/BRIEF.md
# Timer Capture/Compare Channel Zero

This block is a 16-bit up-counter paired with a single channel register. Depending on the operating mode, that register acts in one of three ways. It can be a compare value that raises an interrupt pulse and toggles a timer output pin. It can be a cycle length that clears the counter on a match. It can also be a capture register that takes a snapshot of the counter when a chosen edge arrives on a capture input. Match detection uses a compare buffer behind the register, never the register itself. This lets software rewrite the register while the timer runs without disturbing the period in progress.

The counter advances on each cycle in which the `tick` input is high. That input stands for the divided clock or the external event, which are produced outside this block. A small word-wide register port gives read and write access to the channel register at one fixed offset. Clearing `cnt_en` stops the timer, returns the counter to zero and forces the output pin low.

Top module: `tmr_cc0`

## Requirements
- R1: After a synchronous reset the channel register, compare buffer, counter, `reg_rdata`, `irq_cc` and `tout` are all 0.
- R2: The channel register is reached only at `reg_addr` = 6 and only as a full 16-bit word. A read returns it on `reg_rdata` one cycle after `reg_rd`. A read at any other offset returns 0, and a write at any other offset changes nothing.
- R3: While `cnt_en` = 0 the counter stays at 0 and a written value enters the compare buffer in the same cycle.
- R4: `mode` encodes 0 interval, 1 event count, 2 trigger pulse, 3 one-shot, 4 PWM, 5 free-running, 6 pulse-width and 7 behaves as 0. In modes 0–4 with `cnt_en` = 1, the counter increments on each `tick`. A tick seen while the counter equals the buffer is a match: it loads 0 instead, and `irq_cc` is high for one cycle after that edge. With buffer value B and a steady tick, the period is B+1 cycles.
- R5: While `cnt_en` = 1 the buffer reloads from the register only at a match-clear or at a wrap from 0xFFFF. The reload takes the register value from before that edge, so a write landing on the reload edge applies one period later.
- R6: With `out_en` = 1 each compare match inverts `tout`. With `out_en` = 0, `tout` holds its level.
- R7: In mode 5 with `cap_sel` = 0 a match raises `irq_cc` and toggles `tout` but does not clear the counter. The counter wraps from 0xFFFF to 0.
- R8: In mode 5 with `cap_sel` = 1 a selected capture edge copies the counter value into the channel register and raises `irq_cc`. The counter keeps counting and compare matches are off.
- R9: In mode 6 the register is capture-only, and a selected capture edge also loads the counter with 0.
- R10: `cap_rise` = 1 selects the rising edge of `cap_in` and `cap_rise` = 0 the falling edge. The other edge is ignored.
- R11: Dropping `cnt_en` to 0 sets the counter to 0 and `tout` to 0 at the next edge.
- R12: When a capture and a register write land on the same edge, the captured value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Counter enable |
| mode | input | 3 | Operating mode (encoding in R4) |
| cap_sel | input | 1 | Free-running mode: 1 capture, 0 compare |
| out_en | input | 1 | Timer output toggle enable |
| tick | input | 1 | Count pulse |
| cap_in | input | 1 | Capture input |
| cap_rise | input | 1 | Capture edge: 1 rising, 0 falling |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, one cycle after the strobe |
| count | output | 16 | Current counter value |
| irq_cc | output | 1 | Compare-match / capture interrupt pulse |
| tout | output | 1 | Timer output pin |

## Verification
Two pairs of functions can collide in one cycle. The first pair is a software write and the buffer reload at the end of a period. The bench times a write so that it lands on the match-clear edge. It then expects the old value to govern the next period and the new value only the one after it. The second pair is a capture and a register write. The bench raises the capture edge in the same cycle as a write strobe and reads back the register, which must hold the counter snapshot rather than the written word.

// File: rtl/tmr_cc0_pkg.sv
package tmr_cc0_pkg;

  typedef enum logic [2:0] {
    M_INTERVAL  = 3'd0,
    M_EVENT     = 3'd1,
    M_TRIGPULSE = 3'd2,
    M_ONESHOT   = 3'd3,
    M_PWM       = 3'd4,
    M_FREERUN   = 3'd5,
    M_PULSEW    = 3'd6,
    M_SPARE     = 3'd7
  } mode_e;

  typedef struct packed {
    logic clr_on_match;
    logic cmp_use;
    logic cap_use;
    logic clr_on_cap;
  } role_t;

  function automatic role_t decode_role(input mode_e m, input logic cap_sel);
    role_t r;
    case (m)
      M_FREERUN: begin
        r.clr_on_match = 1'b0;
        r.cmp_use      = ~cap_sel;
        r.cap_use      = cap_sel;
        r.clr_on_cap   = 1'b0;
      end
      M_PULSEW: begin
        r.clr_on_match = 1'b0;
        r.cmp_use      = 1'b0;
        r.cap_use      = 1'b1;
        r.clr_on_cap   = 1'b1;
      end
      default: begin
        r.clr_on_match = 1'b1;
        r.cmp_use      = 1'b1;
        r.cap_use      = 1'b0;
        r.clr_on_cap   = 1'b0;
      end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/tmr_cc0_edge.sv
module tmr_cc0_edge (
  input  logic clk,
  input  logic rst,
  input  logic din,
  input  logic rise_sel,
  output logic edge_o
);
  logic prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= din;
  end

  assign edge_o = rise_sel ? (din & ~prev) : (~din & prev);
endmodule

// File: rtl/tmr_cc0_counter.sv
module tmr_cc0_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         tick,
  input  logic [W-1:0] cmp_val,
  input  logic         cmp_use,
  input  logic         clr_on_match,
  input  logic         cap_clr,
  output logic [W-1:0] cnt_o,
  output logic         match_o,
  output logic         reload_o
);
  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] cnt;

  assign match_o  = en & tick & cmp_use & (cnt == cmp_val);
  assign reload_o = en & tick & ((match_o & clr_on_match) | (cnt == TOP));
  assign cnt_o    = cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
    end else if (cap_clr) begin
      cnt <= '0;
    end else if (tick) begin
      if (match_o && clr_on_match) cnt <= '0;
      else                         cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_cc0_regif.sv
module tmr_cc0_regif #(
  parameter int W   = 16,
  parameter int AW  = 4,
  parameter int OFS = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          wr,
  input  logic          rd,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  input  logic          cap_evt,
  input  logic [W-1:0]  cap_val,
  input  logic          reload,
  output logic [W-1:0]  ccr_o,
  output logic [W-1:0]  buf_o,
  output logic [W-1:0]  rdata_o
);
  localparam logic [AW-1:0] HIT_ADDR = AW'(OFS);

  logic         hit;
  logic [W-1:0] ccr, ccr_nxt, cbuf, rdata;

  assign hit = (addr == HIT_ADDR);

  always_comb begin
    ccr_nxt = ccr;
    if (cap_evt)        ccr_nxt = cap_val;
    else if (wr && hit) ccr_nxt = wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ccr   <= '0;
      cbuf  <= '0;
      rdata <= '0;
    end else begin
      ccr <= ccr_nxt;
      if (!en)         cbuf <= ccr_nxt;
      else if (reload) cbuf <= ccr;
      if (rd)          rdata <= hit ? ccr : '0;
    end
  end

  assign ccr_o   = ccr;
  assign buf_o   = cbuf;
  assign rdata_o = rdata;
endmodule

// File: rtl/tmr_cc0_out.sv
module tmr_cc0_out (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic out_en,
  input  logic match,
  input  logic cap_evt,
  output logic irq_o,
  output logic tout_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o  <= 1'b0;
      tout_o <= 1'b0;
    end else begin
      irq_o <= match | cap_evt;
      if (!en)                  tout_o <= 1'b0;
      else if (match && out_en) tout_o <= ~tout_o;
    end
  end
endmodule

// File: rtl/tmr_cc0.sv
module tmr_cc0
  import tmr_cc0_pkg::*;
#(
  parameter int W   = 16,
  parameter int AW  = 4,
  parameter int OFS = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cnt_en,
  input  logic [2:0]    mode,
  input  logic          cap_sel,
  input  logic          out_en,
  input  logic          tick,
  input  logic          cap_in,
  input  logic          cap_rise,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [W-1:0]  reg_wdata,
  output logic [W-1:0]  reg_rdata,
  output logic [W-1:0]  count,
  output logic          irq_cc,
  output logic          tout
);
  role_t        role;
  logic         cap_edge, cap_evt, match, reload;
  logic [W-1:0] cnt, ccr, cbuf;

  assign role    = decode_role(mode_e'(mode), cap_sel);
  assign cap_evt = cnt_en & role.cap_use & cap_edge;
  assign count   = cnt;

  tmr_cc0_edge u_edge (
    .clk(clk), .rst(rst), .din(cap_in), .rise_sel(cap_rise), .edge_o(cap_edge)
  );

  tmr_cc0_counter #(.W(W)) u_cnt (
    .clk(clk), .rst(rst), .en(cnt_en), .tick(tick), .cmp_val(cbuf),
    .cmp_use(role.cmp_use), .clr_on_match(role.clr_on_match),
    .cap_clr(cap_evt & role.clr_on_cap),
    .cnt_o(cnt), .match_o(match), .reload_o(reload)
  );

  tmr_cc0_regif #(.W(W), .AW(AW), .OFS(OFS)) u_reg (
    .clk(clk), .rst(rst), .en(cnt_en), .wr(reg_wr), .rd(reg_rd),
    .addr(reg_addr), .wdata(reg_wdata), .cap_evt(cap_evt), .cap_val(cnt),
    .reload(reload), .ccr_o(ccr), .buf_o(cbuf), .rdata_o(reg_rdata)
  );

  tmr_cc0_out u_out (
    .clk(clk), .rst(rst), .en(cnt_en), .out_en(out_en), .match(match),
    .cap_evt(cap_evt), .irq_o(irq_cc), .tout_o(tout)
  );
endmodule

// File: rtl/tmr_cc0_chk.sv
module tmr_cc0_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         cnt_en,
  input logic [2:0]   mode,
  input logic         tick,
  input logic         irq_cc,
  input logic         tout,
  input logic [W-1:0] count
);
  AST_STOP_CLEARS_PIN: assert property (@(posedge clk) disable iff (rst)
    !cnt_en |=> !tout); // R11

  AST_STOP_CLEARS_COUNT: assert property (@(posedge clk) disable iff (rst)
    !cnt_en |=> (count == '0)); // R11

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    irq_cc |-> $past(cnt_en)); // R4

  AST_PIN_MOVES_ON_IRQ: assert property (@(posedge clk) disable iff (rst)
    ($past(cnt_en) && (tout != $past(tout))) |-> irq_cc); // R6

  AST_FREERUN_STEPS: assert property (@(posedge clk) disable iff (rst)
    ($past(cnt_en) && $past(tick) && ($past(mode) == 3'd5) && cnt_en)
      |-> (count == $past(count) + 1'b1)); // R7
endmodule

bind tmr_cc0 tmr_cc0_chk #(.W(W)) i_chk (
  .clk(clk), .rst(rst), .cnt_en(cnt_en), .mode(mode), .tick(tick),
  .irq_cc(irq_cc), .tout(tout), .count(count)
);

// File: tb/test_tmr_cc0.sv
module test_tmr_cc0;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cnt_en = 1'b0, cap_sel = 1'b0, out_en = 1'b0, tick = 1'b1;
  logic        cap_in = 1'b0, cap_rise = 1'b1, reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic [3:0]  reg_addr = 4'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata, count;
  logic        irq_cc, tout;

  int cyc = 0;
  int n_chk = 0;
  int n_err = 0;

  typedef struct { int cyc; string req; } exp_t;
  exp_t q[$];

  tmr_cc0 i_tmr_cc0 (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .mode(mode), .cap_sel(cap_sel),
    .out_en(out_en), .tick(tick), .cap_in(cap_in), .cap_rise(cap_rise),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .count(count), .irq_cc(irq_cc), .tout(tout)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic push(int c, string req);
    exp_t e;
    e.cyc = c;
    e.req = req;
    q.push_back(e);
  endtask

  // Monitor: compares each interrupt pulse with the next queued expectation
  always @(negedge clk) begin
    if (!rst) begin
      if (q.size() > 0 && q[0].cyc < cyc) begin
        exp_t m;
        m = q.pop_front();
        chk({m.req, " missed irq"}, -1, m.cyc);
      end
      if (irq_cc) begin
        if (q.size() == 0) begin
          chk("R4/R8 unexpected irq", cyc, -1);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk({e.req, " irq cycle"}, cyc, e.cyc);
        end
      end
    end
  end

  task automatic wait_cyc(int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic reg_write(logic [3:0] a, logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(logic [3:0] a, output logic [15:0] d);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] rd;
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 count", int'(count), 0);
    chk("R1 irq", int'(irq_cc), 0);
    chk("R1 tout", int'(tout), 0);
    chk("R1 rdata", int'(reg_rdata), 0);
    rst = 1'b0;
    @(negedge clk);
    reg_read(4'd6, rd);
    chk("R1 register", int'(rd), 0);

    // R2 offset decode
    reg_write(4'd6, 16'd3);
    reg_write(4'd4, 16'h0055);
    reg_read(4'd6, rd);
    chk("R2 read at offset 6", int'(rd), 3);
    reg_read(4'd4, rd);
    chk("R2 read elsewhere", int'(rd), 0);

    // R3/R4/R5/R6: interval mode, buffer loaded while stopped
    mode = 3'd0; out_en = 1'b1; tick = 1'b1;
    n = cyc;
    cnt_en = 1'b1;
    push(n + 4, "R3/R4");
    push(n + 12, "R5 new value next period");
    push(n + 20, "R5 coincident write deferred");
    push(n + 23, "R5 deferred value applied");
    wait_cyc(n + 2);
    reg_addr = 4'd6; reg_wdata = 16'd7; reg_wr = 1'b1;
    wait_cyc(n + 3);
    reg_wr = 1'b0;
    chk("R6 tout before match", int'(tout), 0);
    wait_cyc(n + 4);
    chk("R6 tout first toggle", int'(tout), 1);
    chk("R4 clear on match", int'(count), 0);
    wait_cyc(n + 11);
    reg_wdata = 16'd2; reg_wr = 1'b1;
    wait_cyc(n + 12);
    reg_wr = 1'b0;
    chk("R6 tout second toggle", int'(tout), 0);
    wait_cyc(n + 13);
    out_en = 1'b0;
    wait_cyc(n + 20);
    chk("R6 tout held with out_en=0", int'(tout), 0);
    wait_cyc(n + 21);
    out_en = 1'b1;
    wait_cyc(n + 23);
    chk("R6 tout toggles again", int'(tout), 1);
    chk("R4 count after short period", int'(count), 0);
    wait_cyc(n + 24);
    cnt_en = 1'b0;
    wait_cyc(n + 25);
    chk("R11 tout after stop", int'(tout), 0);
    chk("R11 count after stop", int'(count), 0);
    repeat (2) @(negedge clk);
    chk("R3 count held while stopped", int'(count), 0);

    // R7 free-running compare with wrap and reload
    reg_write(4'd6, 16'd10);
    mode = 3'd5; cap_sel = 1'b0;
    n = cyc;
    cnt_en = 1'b1;
    push(n + 11, "R7 first match");
    push(n + 65557, "R7 match after wrap reload");
    wait_cyc(n + 12);
    chk("R7 no clear on match", int'(count), 12);
    wait_cyc(n + 50);
    reg_addr = 4'd6; reg_wdata = 16'd20; reg_wr = 1'b1;
    wait_cyc(n + 51);
    reg_wr = 1'b0;
    wait_cyc(n + 65536);
    chk("R7 wrap to zero", int'(count), 0);
    wait_cyc(n + 65558);
    cnt_en = 1'b0;
    @(negedge clk);

    // R8/R10 free-running capture
    reg_write(4'd6, 16'd5);
    cap_sel = 1'b1; cap_rise = 1'b1; cap_in = 1'b0;
    @(negedge clk);
    n = cyc;
    cnt_en = 1'b1;
    wait_cyc(n + 20);
    cap_in = 1'b1;
    push(n + 21, "R8 capture");
    wait_cyc(n + 21);
    chk("R8 counter keeps running", int'(count), 21);
    wait_cyc(n + 22);
    reg_addr = 4'd6; reg_rd = 1'b1;
    wait_cyc(n + 23);
    reg_rd = 1'b0;
    chk("R8 captured value", int'(reg_rdata), 20);
    wait_cyc(n + 30);
    cap_in = 1'b0;           // R10 falling edge ignored while rising selected
    wait_cyc(n + 35);
    cap_rise = 1'b0;
    wait_cyc(n + 40);
    cap_in = 1'b1;           // R10 rising edge ignored while falling selected
    wait_cyc(n + 50);
    cap_in = 1'b0;
    push(n + 51, "R10 falling capture");
    wait_cyc(n + 52);
    reg_rd = 1'b1;
    wait_cyc(n + 53);
    reg_rd = 1'b0;
    chk("R10 falling edge value", int'(reg_rdata), 50);
    cnt_en = 1'b0;
    @(negedge clk);

    // R9/R12 pulse-width capture
    mode = 3'd6; cap_rise = 1'b1;
    @(negedge clk);
    n = cyc;
    cnt_en = 1'b1;
    wait_cyc(n + 15);
    cap_in = 1'b1;
    push(n + 16, "R9 capture");
    wait_cyc(n + 16);
    chk("R9 counter cleared on capture", int'(count), 0);
    wait_cyc(n + 20);
    cap_in = 1'b0;
    wait_cyc(n + 25);
    cap_in = 1'b1;
    reg_addr = 4'd6; reg_wdata = 16'h1234; reg_wr = 1'b1;
    push(n + 26, "R12 capture with write");
    wait_cyc(n + 26);
    reg_wr = 1'b0; reg_rd = 1'b1;
    chk("R9 counter cleared again", int'(count), 0);
    wait_cyc(n + 27);
    reg_rd = 1'b0;
    chk("R12 capture wins over write", int'(reg_rdata), 9);
    cnt_en = 1'b0;
    repeat (5) @(negedge clk);
    chk("R4 pending expectations", q.size(), 0);
    summary();
    $finish;
  end
endmodule